// File: doc/BRIEF.md
# Byte-Packing Transmit/Receive Queue for a Serial Shifter

This block sits between a 16-bit bus data port and a serial shift engine that moves frames of 8 bits or fewer. Two small byte-wide queues hold the frames. The transmit queue is loaded from bus writes. A 16-bit write carries two frames and an 8-bit write carries one. The shift engine takes frames from the transmit queue one at a time through a valid/ready port. Frames the engine has received enter the receive queue one per cycle, and bus reads take them back out. A wide read removes up to two frames and a narrow read removes one.

Frames always travel low byte first. The low half of a wide write is shifted out before the high half. The earlier of two received frames appears in the low half of a wide read. A receive-ready flag gives software its cue to read. A threshold select decides whether that flag needs two held frames or only one. Setting the select to one frame lets software drain a final odd frame with a narrow read.

The block also reports the following status: a transmit-room flag, a 2-bit receive fill code, a busy flag that covers frames still being shifted, and a sticky receive-overrun flag.

Top module: `spi_pack_fifo`

## Requirements
- R1: A 16-bit write (`wr_wide`=1) queues `wr_data[7:0]` as the earlier frame and `wr_data[15:8]` as the later one. The head frame is presented on `tx_data`, so writing 0x040A shifts out 0x0A and then 0x04.
- R2: An 8-bit write (`wr_wide`=0) queues exactly one frame, `wr_data[7:0]`. The upper bits are ignored.
- R3: Each queue holds 4 bytes. A write is dropped whole, with no error, when free space is less than its frame count. `txe` is 1 exactly when at least 2 transmit bytes are free.
- R4: With `rx_th8`=0, `rxne` is 1 only while 2 or more frames are held. With `rx_th8`=1, `rxne` is 1 while 1 or more frames are held.
- R5: A wide read pops two frames and returns them on `rd_data` in the cycle after `rd_en`, with the first received frame in bits 7:0. Receiving 0x0A then 0x04 reads back as 0x040A.
- R6: A read removes no more frames than are held. A wide read with one frame held returns {0x00, frame} and pops it. A read of an empty queue returns 0x0000. `rd_data` holds its value between reads.
- R7: `rx_level` is 00 when the receive queue is empty, 01 for 1 byte, 10 for 2 or 3 bytes, and 11 for 4 bytes.
- R8: A frame that arrives while the receive queue is full is dropped and sets `ovr`. `ovr` clears only when a data read made while it is set is followed later by a `stat_rd` pulse.
- R9: Once a frame is handed over (`tx_valid`&`tx_ready`), `busy` stays 1 until `tx_done`. `busy` is also 1 while `en`=1 and transmit frames are queued.
- R10: With `en`=0, `tx_valid` is 0 and no frames leave the transmit queue. Both queues keep their contents.
- R11: After reset, `txe`=1, `rxne`=0, `rx_level`=00, `busy`=0, `ovr`=0, `tx_valid`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Allows frames to leave the transmit queue |
| rx_th8 | input | 1 | Receive threshold: 1 = one frame, 0 = two frames |
| wr_en | input | 1 | Bus write strobe |
| wr_wide | input | 1 | 1 = 16-bit write, 0 = 8-bit write |
| wr_data | input | 16 | Write data, low byte first |
| rd_en | input | 1 | Bus read strobe |
| rd_wide | input | 1 | 1 = 16-bit read, 0 = 8-bit read |
| rd_data | output | 16 | Read result, registered |
| stat_rd | input | 1 | Status read strobe (second step of the overrun clear) |
| txe | output | 1 | At least half the transmit queue is free |
| rxne | output | 1 | Receive data ready under the selected threshold |
| rx_level | output | 2 | Receive fill code |
| busy | output | 1 | Transfer still in progress |
| ovr | output | 1 | Sticky receive overrun |
| tx_valid | output | 1 | Frame offered to the shift engine |
| tx_data | output | 8 | Head transmit frame |
| tx_ready | input | 1 | Shift engine takes the frame |
| tx_done | input | 1 | Shift engine finished the handed-over frame |
| rx_valid | input | 1 | Received frame strobe |
| rx_data | input | 8 | Received frame |

## Verification
A write, a handover, a received frame or a status read changes the queue counts and flags at the next rising edge. `txe`, `rxne`, `rx_level`, `busy`, `ovr` and `tx_data` therefore settle one cycle after the strobe. `rd_data` is also due one cycle after `rd_en`, because it is registered. `tx_valid` and `busy` also follow `en` with no delay.

The bench drives inputs on the falling edge. Its queue model advances on the rising edge from the same inputs. It compares every output at the next falling edge, before new inputs are applied. Each comparison therefore sees exactly one edge's worth of change.

// File: rtl/spi_pack_pkg.sv
package spi_pack_pkg;

  typedef enum logic [1:0] {
    LVL_EMPTY = 2'b00,
    LVL_ONE   = 2'b01,
    LVL_PART  = 2'b10,
    LVL_FULL  = 2'b11
  } fill_code_e;

  // Map a byte count onto the 2-bit fill code.
  function automatic fill_code_e fill_code(input int unsigned cnt, input int unsigned depth);
    if (cnt == 0)          return LVL_EMPTY;
    else if (cnt == 1)     return LVL_ONE;
    else if (cnt >= depth) return LVL_FULL;
    else                   return LVL_PART;
  endfunction

endpackage

// File: rtl/spi_pack_byte_fifo.sv
// Byte queue that accepts 0..2 bytes and releases 0..2 bytes per cycle.
// The caller guarantees that pushes fit and pops do not exceed the count.
module spi_pack_byte_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    push_n,
  input  logic [2*W-1:0] push_data,
  input  logic [1:0]    pop_n,
  output logic [2*W-1:0] head_data,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp, wp1, rp1;

  assign wp1 = wp + 1'b1;
  assign rp1 = rp + 1'b1;

  always_ff @(posedge clk) begin
    if (push_n != 2'd0) mem[wp]  <= push_data[W-1:0];
    if (push_n == 2'd2) mem[wp1] <= push_data[2*W-1:W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      wp    <= wp + PW'(push_n);
      rp    <= rp + PW'(pop_n);
      count <= count + CW'(push_n) - CW'(pop_n);
    end
  end

  assign head_data = {mem[rp1], mem[rp]};

endmodule

// File: rtl/spi_pack_ovr.sv
// Sticky overrun flag with a two-step clear: data read, then status read.
module spi_pack_ovr (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic rd_i,
  input  logic stat_i,
  output logic flag_o
);

  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      armed  <= 1'b0;
    end else if (set_i) begin
      flag_o <= 1'b1;
      armed  <= 1'b0;
    end else if (stat_i && armed) begin
      flag_o <= 1'b0;
      armed  <= 1'b0;
    end else if (rd_i && flag_o) begin
      armed  <= 1'b1;
    end
  end

endmodule

// File: rtl/spi_pack_fifo.sv
module spi_pack_fifo #(
  parameter int DEPTH = 4,
  parameter int FW    = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          rx_th8,
  input  logic          wr_en,
  input  logic          wr_wide,
  input  logic [2*FW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rd_wide,
  output logic [2*FW-1:0] rd_data,
  input  logic          stat_rd,
  output logic          txe,
  output logic          rxne,
  output logic [1:0]    rx_level,
  output logic          busy,
  output logic          ovr,
  output logic          tx_valid,
  output logic [FW-1:0] tx_data,
  input  logic          tx_ready,
  input  logic          tx_done,
  input  logic          rx_valid,
  input  logic [FW-1:0] rx_data
);
  import spi_pack_pkg::*;

  logic [CW-1:0]   tx_cnt, rx_cnt, tx_free;
  logic [2*FW-1:0] tx_head, rx_head;
  logic [1:0]      wr_need, tx_push, tx_pop, rd_want, rx_pop, rx_push;
  logic            tx_take, rx_full, ovr_set, inflight;

  // Transmit side
  assign tx_free  = CW'(DEPTH) - tx_cnt;
  assign wr_need  = wr_wide ? 2'd2 : 2'd1;
  assign tx_push  = (wr_en && (tx_free >= CW'(wr_need))) ? wr_need : 2'd0;
  assign tx_valid = en && (tx_cnt != '0);
  assign tx_take  = tx_valid && tx_ready;
  assign tx_pop   = {1'b0, tx_take};
  assign tx_data  = tx_head[FW-1:0];

  spi_pack_byte_fifo #(.DEPTH(DEPTH), .W(FW)) u_txq (
    .clk(clk), .rst(rst), .push_n(tx_push), .push_data(wr_data),
    .pop_n(tx_pop), .head_data(tx_head), .count(tx_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst)          inflight <= 1'b0;
    else if (tx_take) inflight <= 1'b1;
    else if (tx_done) inflight <= 1'b0;
  end

  // Receive side
  assign rx_full = (rx_cnt == CW'(DEPTH));
  assign rx_push = (rx_valid && !rx_full) ? 2'd1 : 2'd0;
  assign ovr_set = rx_valid && rx_full;
  assign rd_want = rd_wide ? 2'd2 : 2'd1;
  assign rx_pop  = !rd_en ? 2'd0 :
                   (rx_cnt >= CW'(rd_want)) ? rd_want : 2'(rx_cnt);

  spi_pack_byte_fifo #(.DEPTH(DEPTH), .W(FW)) u_rxq (
    .clk(clk), .rst(rst), .push_n(rx_push), .push_data({{FW{1'b0}}, rx_data}),
    .pop_n(rx_pop), .head_data(rx_head), .count(rx_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      rd_data[FW-1:0]    <= (rx_pop != 2'd0) ? rx_head[FW-1:0]    : '0;
      rd_data[2*FW-1:FW] <= (rx_pop == 2'd2) ? rx_head[2*FW-1:FW] : '0;
    end
  end

  spi_pack_ovr u_ovr (
    .clk(clk), .rst(rst), .set_i(ovr_set), .rd_i(rd_en),
    .stat_i(stat_rd), .flag_o(ovr)
  );

  // Status
  assign txe      = (tx_free >= CW'(2));
  assign rxne     = rx_th8 ? (rx_cnt != '0) : (rx_cnt >= CW'(2));
  assign rx_level = fill_code(int'(rx_cnt), DEPTH);
  assign busy     = inflight || tx_valid;

endmodule

// File: rtl/spi_pack_fifo_chk.sv
module spi_pack_fifo_chk #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          rx_th8,
  input logic          wr_en,
  input logic          rd_en,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          txe,
  input logic          rxne,
  input logic [1:0]    rx_level,
  input logic          busy,
  input logic          ovr,
  input logic          rx_valid,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);

  // R3: a full transmit queue with no frame leaving stays full
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt == CW'(DEPTH) && !(tx_valid && tx_ready)) |=> (tx_cnt == CW'(DEPTH)));

  // R3: full transmit queue reports no room
  a_r3_txe_full: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt == CW'(DEPTH)) |-> !txe);

  // R4: one-frame threshold raises rxne on any held frame
  a_r4_rxne_one: assert property (@(posedge clk) disable iff (rst)
    (rx_th8 && rx_cnt != '0) |-> rxne);

  // R4: two-frame threshold keeps rxne low with fewer than two frames
  a_r4_rxne_two: assert property (@(posedge clk) disable iff (rst)
    (!rx_th8 && rx_cnt < CW'(2)) |-> !rxne);

  // R7: empty receive queue reports code 00
  a_r7_level_empty: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt == '0) |-> (rx_level == 2'b00));

  // R8: a frame arriving into a full receive queue sets the overrun flag
  a_r8_ovr_set: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_cnt == CW'(DEPTH)) |=> ovr);

  // R8: the dropped frame does not change a full queue that is not read
  a_r8_drop: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_cnt == CW'(DEPTH) && !rd_en) |=> (rx_cnt == CW'(DEPTH)));

  // R9: a handover keeps busy high in the following cycle
  a_r9_busy_after_take: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> busy);

  // R10: disabled block offers nothing to the shifter
  a_r10_no_offer: assert property (@(posedge clk) disable iff (rst)
    !en |-> !tx_valid);

  // R10: disabled block with no write keeps the transmit count
  a_r10_retained: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_en) |=> (tx_cnt == $past(tx_cnt)));

endmodule

bind spi_pack_fifo spi_pack_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .en(en), .rx_th8(rx_th8), .wr_en(wr_en), .rd_en(rd_en),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .txe(txe), .rxne(rxne),
  .rx_level(rx_level), .busy(busy), .ovr(ovr), .rx_valid(rx_valid),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/tb_spi_pack_fifo.sv
module tb_spi_pack_fifo;
  localparam int CLK_P = 10;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst, en, rx_th8, wr_en, wr_wide, rd_en, rd_wide, stat_rd;
  logic tx_ready, tx_done, rx_valid;
  logic [15:0] wr_data, rd_data;
  logic [7:0]  rx_data, tx_data;
  logic txe, rxne, busy, ovr, tx_valid;
  logic [1:0] rx_level;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_pack_fifo #(.DEPTH(DEPTH), .FW(8)) dut (.*);

  // Reference model
  byte unsigned txq[$];
  byte unsigned rxq[$];
  bit m_inflight, m_ovr, m_armed;
  logic [15:0] m_rd;
  int tsz, rsz, n;
  bit take, oset;

  always @(posedge clk) begin
    if (rst) begin
      txq.delete(); rxq.delete();
      m_inflight = 0; m_ovr = 0; m_armed = 0; m_rd = 0;
    end else begin
      tsz = txq.size(); rsz = rxq.size();
      take = en && tsz > 0 && tx_ready;
      if (take) void'(txq.pop_front());
      if (take) m_inflight = 1; else if (tx_done) m_inflight = 0;
      if (wr_en && (DEPTH - tsz) >= (wr_wide ? 2 : 1)) begin
        txq.push_back(wr_data[7:0]);
        if (wr_wide) txq.push_back(wr_data[15:8]);
      end
      if (rd_en) begin
        n = rd_wide ? 2 : 1;
        if (n > rsz) n = rsz;
        m_rd = 16'h0;
        if (n >= 1) m_rd[7:0]  = rxq.pop_front();
        if (n == 2) m_rd[15:8] = rxq.pop_front();
      end
      oset = rx_valid && rsz == DEPTH;
      if (oset) begin m_ovr = 1; m_armed = 0; end
      else if (stat_rd && m_armed) begin m_ovr = 0; m_armed = 0; end
      else if (rd_en && m_ovr) m_armed = 1;
      if (rx_valid && rsz < DEPTH) rxq.push_back(rx_data);
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] lvl(input int c);
    if (c == 0) return 2'b00;
    if (c == 1) return 2'b01;
    if (c >= DEPTH) return 2'b11;
    return 2'b10;
  endfunction

  task automatic compare();
    chk("R3 txe", 16'(txe), 16'((DEPTH - txq.size()) >= 2));
    chk("R4 rxne", 16'(rxne), 16'(rx_th8 ? rxq.size() >= 1 : rxq.size() >= 2));
    chk("R7 rx_level", 16'(rx_level), 16'(lvl(rxq.size())));
    chk("R9 busy", 16'(busy), 16'(m_inflight || (en && txq.size() > 0)));
    chk("R10 tx_valid", 16'(tx_valid), 16'(en && txq.size() > 0));
    if (tx_valid) chk("R1 tx_data", 16'(tx_data), 16'(txq[0]));
    chk("R8 ovr", 16'(ovr), 16'(m_ovr));
    chk("R5 rd_data", rd_data, m_rd);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; stat_rd = 0; tx_ready = 0; tx_done = 0; rx_valid = 0;
  endtask

  task automatic bus_wr(input bit wide, input logic [15:0] d);
    wr_en = 1; wr_wide = wide; wr_data = d; step(); wr_en = 0;
  endtask

  task automatic bus_rd(input bit wide);
    rd_en = 1; rd_wide = wide; step(); rd_en = 0;
  endtask

  task automatic rx_in(input logic [7:0] d);
    rx_valid = 1; rx_data = d; step(); rx_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst = 1; en = 0; rx_th8 = 0; wr_wide = 0; rd_wide = 0;
    wr_data = 0; rx_data = 0; idle();
    step(); step();
    rst = 0;
    step();
    // R11: reset state
    chk("R11 txe", 16'(txe), 16'h1);
    chk("R11 rxne", 16'(rxne), 16'h0);
    chk("R11 rx_level", 16'(rx_level), 16'h0);
    chk("R11 busy", 16'(busy), 16'h0);
    chk("R11 ovr", 16'(ovr), 16'h0);
    chk("R11 tx_valid", 16'(tx_valid), 16'h0);
    chk("R11 rd_data", rd_data, 16'h0);

    // R1 / R10: wide write while disabled
    bus_wr(1, 16'h040A);
    step();
    chk("R10 no offer while disabled", 16'(tx_valid), 16'h0);
    en = 1; #1;
    chk("R1 first frame low byte", 16'(tx_data), 16'h000A);
    tx_ready = 1; step(); tx_ready = 0;
    chk("R1 second frame high byte", 16'(tx_data), 16'h0004);
    chk("R9 busy after handover", 16'(busy), 16'h1);
    tx_ready = 1; step(); tx_ready = 0;
    chk("R9 busy until done", 16'(busy), 16'h1);
    tx_done = 1; step(); tx_done = 0;
    chk("R9 busy drops after done", 16'(busy), 16'h0);

    // R2: narrow write queues one frame
    en = 0;
    bus_wr(0, 16'h5577);
    chk("R2 one frame txe", 16'(txe), 16'h1);
    bus_wr(1, 16'h2211);
    chk("R2 txe after 3 bytes", 16'(txe), 16'h0);
    // R3: wide write with one free byte dropped, narrow fits
    bus_wr(1, 16'h4433);
    bus_wr(0, 16'h0099);
    bus_wr(0, 16'h0088);
    en = 1; #1;
    chk("R2 head is narrow frame", 16'(tx_data), 16'h0077);
    tx_ready = 1;
    step(); chk("R1 order a", 16'(tx_data), 16'h0011);
    step(); chk("R1 order b", 16'(tx_data), 16'h0022);
    step(); chk("R3 dropped wide write", 16'(tx_data), 16'h0099);
    step(); tx_ready = 0; tx_done = 1; step(); tx_done = 0;

    // R4 / R5: two-frame threshold and wide read
    rx_th8 = 0;
    rx_in(8'h0A);
    chk("R4 rxne low with one frame", 16'(rxne), 16'h0);
    rx_in(8'h04);
    chk("R4 rxne high with two", 16'(rxne), 16'h1);
    chk("R7 level two", 16'(rx_level), 16'h2);
    bus_rd(1);
    chk("R5 packed read", rd_data, 16'h040A);
    chk("R7 level empty after read", 16'(rx_level), 16'h0);

    // R6: lone frame with one-frame threshold
    rx_in(8'h33);
    chk("R4 rxne low at threshold two", 16'(rxne), 16'h0);
    rx_th8 = 1; #1;
    chk("R4 rxne high at threshold one", 16'(rxne), 16'h1);
    chk("R7 level one", 16'(rx_level), 16'h1);
    bus_rd(1);
    chk("R6 wide read of lone frame", rd_data, 16'h0033);
    bus_rd(0);
    chk("R6 read of empty", rd_data, 16'h0000);
    step();
    chk("R6 rd_data held", rd_data, 16'h0000);

    // R8: overrun
    for (int i = 0; i < 5; i++) rx_in(8'(8'h40 + i));
    chk("R7 level full", 16'(rx_level), 16'h3);
    chk("R8 ovr set", 16'(ovr), 16'h1);
    stat_rd = 1; step(); stat_rd = 0;
    chk("R8 status alone does not clear", 16'(ovr), 16'h1);
    bus_rd(0);
    chk("R8 oldest frame kept", rd_data, 16'h0040);
    stat_rd = 1; step(); stat_rd = 0;
    chk("R8 cleared by read then status", 16'(ovr), 16'h0);
    bus_rd(1);
    chk("R8 dropped frame absent", rd_data, 16'h4241);
    bus_rd(1);
    chk("R8 last stored frame", rd_data, 16'h0043);

    // Random traffic, compared every cycle
    for (int c = 0; c < 4000; c++) begin
      en       = ($urandom % 8) != 0;
      rx_th8   = $urandom % 2;
      wr_en    = ($urandom % 3) == 0;
      wr_wide  = $urandom % 2;
      wr_data  = 16'($urandom);
      rd_en    = ($urandom % 3) == 0;
      rd_wide  = $urandom % 2;
      stat_rd  = ($urandom % 4) == 0;
      tx_ready = $urandom % 2;
      tx_done  = ($urandom % 3) == 0;
      rx_valid = ($urandom % 2) == 0;
      rx_data  = 8'($urandom);
      step();
    end
    idle();
    step();
    finish_run();
  end

endmodule